// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a control-port slave that lets an external I2C master read and write a bank of 8-bit configuration registers. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It compares the address byte against a fixed six-bit prefix plus one bit taken from a board strap. SDA is driven only through an open-drain enable: `sda_oe` high means the line is pulled low.

A write transfer carries the address byte, then a pointer byte, then any number of data bytes. The pointer byte selects the target register and sets an increment flag. A read transfer returns the register that the pointer currently selects. When the increment flag is set, the transfer streams through the following registers and wraps from the last one back to the first. When the flag is clear, each transfer touches a single register.

The register contents leave the block on a flat bus so that surrounding logic can use them directly.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register i (1..NUM_REGS) holds i*0x11, the pointer selects index 1 with increment off, and `sda_oe` is low.
- R2: The 7-bit slave address is binary 001000 followed by the level of `addr_sel`. Bit 0 of the address byte is the direction, where 1 means read. An address byte that does not match gets no ACK, and everything up to the next START is ignored.
- R3: The slave pulls SDA low during the ninth SCL clock of a matching address byte and of every byte written to it.
- R4: A read returns, MSB first, the register at the pointer's current index. The pointer keeps its value across STOP and across read transfers. Before any pointer write, it selects index 1.
- R5: In a write transfer, the first byte after the address byte loads the pointer: bit 7 is the increment flag and bits 6..0 are the register index. Each following byte is written to the register at that index.
- R6: With the increment flag set, the index advances by one after each data byte written and after each read byte that the master ACKs.
- R7: With the increment flag clear, successive written bytes all go to the same register. A master ACK after the first read byte ends the transfer, so SDA stays released and further bytes read as 0xFF.
- R8: An index advance from NUM_REGS, or from any unimplemented index, lands on index 1.
- R9: Indices 0 and above NUM_REGS are unimplemented. Writes to them are acknowledged and change nothing, and reads of them return 0x00.
- R10: A START in the middle of a byte abandons that byte and begins a new address phase. A STOP returns the slave to idle, releases SDA and leaves the pointer unchanged.
- R11: `sda_oe` and the register contents change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (resolved bus) |
| addr_sel | input | 1 | Strap that supplies the low address bit |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| regs_o | output | 8*NUM_REGS | Register i at bits [8*i-1 : 8*(i-1)] |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except to form START and STOP. They also assume that every SCL low phase lasts longer than the synchronizer delay plus one cycle, so the slave's output changes settle inside the low phase. The assertions further assume that no START or STOP is attempted while the slave holds SDA low. The stimulus meets these assumptions by driving every bus edge from tasks that space SCL and SDA transitions a quarter bit, ten system clocks, apart. It forms START and STOP only after the slave has released the line.

// File: rtl/cfg_i2c_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, state encoding and helper functions for the
// I2C configuration register slave.
package cfg_i2c_pkg;

    // Fixed upper six bits of the 7-bit slave address.
    localparam logic [5:0] DEV_ADDR_HI = 6'b001000;

    // Width of the register index field of the pointer byte.
    localparam int IDX_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_END,  // address complete, decide on ACK at next SCL fall
        ST_ACK_ADDR,  // driving ACK for the address byte
        ST_WR_BIT,    // shifting in a written byte
        ST_WR_END,    // written byte complete, commit at next SCL fall
        ST_ACK_WR,    // driving ACK for a written byte
        ST_RD_BIT,    // shifting a register byte out
        ST_RD_ACK     // sampling the master's ACK/NACK
    } bus_state_t;

    // Reset contents of register i (1-based).
    function automatic logic [7:0] reg_reset_value(int unsigned idx);
        return 8'(idx * 32'd17);
    endfunction

    // Next index for auto-increment: wraps to 1 from the top or from any
    // unimplemented index.
    function automatic logic [IDX_W-1:0] next_index(logic [IDX_W-1:0] idx,
                                                    int unsigned top);
        if (idx == '0 || 32'(idx) >= top)
            return IDX_W'(1);
        return idx + IDX_W'(1);
    endfunction

endpackage

// File: rtl/cfg_i2c_line_sync.sv
`timescale 1ns/1ps
// Module: cfg_i2c_line_sync
// Brings SCL and SDA into the clock domain through a flop chain and derives
// single-cycle events: SCL rising, SCL falling, START and STOP.
// Assumes: the bus idles high; every SCL phase lasts several clock cycles.
module cfg_i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_d;
    logic          sda_d;
    logic          scl_s;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[LAST-1:0], scl_i};
            sda_ff <= {sda_ff[LAST-1:0], sda_i};
            scl_d  <= scl_ff[LAST];
            sda_d  <= sda_ff[LAST];
        end
    end

    // Event decode: START/STOP are SDA edges while SCL stays high.
    always_comb begin
        scl_s     = scl_ff[LAST];
        sda_s     = sda_ff[LAST];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
// Module: cfg_reg_bank
// Bank of NUM_REGS 8-bit registers at indices 1..NUM_REGS with one write
// port and one combinational read port. Unimplemented indices ignore writes
// and read as zero.
// Assumes: NUM_REGS below 127 so every register has a 7-bit index.
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;

        // One register: loads its reset value, then accepts matching writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= reg_reset_value(g + 1);
            else if (wr_en && wr_idx == IDX_W'(g + 1))
                q <= wr_data;
        end

        assign regs_o[g*8 +: 8] = q;
    end

    // Read mux: zero unless the index names an implemented register.
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i + 1))
                rd_data = regs_o[i*8 +: 8];
    end

endmodule

// File: rtl/cfg_i2c_proto.sv
`timescale 1ns/1ps
// Module: cfg_i2c_proto
// Byte-level I2C slave protocol: address match, ACK generation, pointer
// load, register write strobes and read data shifting.
// Assumes: events come from cfg_i2c_line_sync; SDA output changes are made
// only on detected SCL falls, which keeps them inside the low phase.
module cfg_i2c_proto
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] DEFAULT_MAP = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_sel,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [7:0]       rd_data,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] map_idx,
    output logic             sda_oe
);
    bus_state_t state;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] map_q;
    logic       rw_q;
    logic       first_q;
    logic       ack_q;
    logic       addr_hit;

    // Address compare and register write strobe.
    always_comb begin
        addr_hit = (shreg[7:1] == {DEV_ADDR_HI, addr_sel});
        wr_en    = (state == ST_WR_END) && scl_fall && !first_q &&
                   !start_evt && !stop_evt;
        wr_data  = shreg;
        map_idx  = map_q[IDX_W-1:0];
    end

    // Protocol sequencer; START and STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            map_q   <= DEFAULT_MAP;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            ack_q   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_evt) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_evt) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7)
                            state <= ST_ADDR_END;
                    end
                end
                ST_ADDR_END: begin
                    if (scl_fall) begin
                        if (addr_hit) begin
                            rw_q   <= shreg[0];
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_ADDR;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RD_BIT;
                        end else begin
                            sda_oe  <= 1'b0;
                            first_q <= 1'b1;
                            state   <= ST_WR_BIT;
                        end
                    end
                end
                ST_WR_BIT: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7)
                            state <= ST_WR_END;
                    end
                end
                ST_WR_END: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b1;
                        first_q <= 1'b0;
                        state   <= ST_ACK_WR;
                        if (first_q)
                            map_q <= shreg;
                        else if (map_q[7])
                            map_q[IDX_W-1:0] <= next_index(map_q[IDX_W-1:0], NUM_REGS);
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WR_BIT;
                    end
                end
                ST_RD_BIT: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_oe  <= ~shreg[6];
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ack_q <= ~sda_s;
                        if (!sda_s && map_q[7])
                            map_q[IDX_W-1:0] <= next_index(map_q[IDX_W-1:0], NUM_REGS);
                    end else if (scl_fall) begin
                        if (ack_q && map_q[7]) begin
                            shreg   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            bit_cnt <= '0;
                            state   <= ST_RD_BIT;
                        end else begin
                            state   <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_i2c_slave.sv
`timescale 1ns/1ps
// Module: cfg_i2c_slave (top)
// I2C slave giving a master pointer-based access to a register bank.
// Assumes: sda_i is the resolved open-drain line including this block's own
// drive; the master respects the I2C data-setup rules and never stretches.
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DEFAULT_MAP = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_sel,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_evt;
    logic             stop_evt;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;
    logic [IDX_W-1:0] map_idx;

    cfg_i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    cfg_i2c_proto #(
        .NUM_REGS   (NUM_REGS),
        .DEFAULT_MAP(DEFAULT_MAP)
    ) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .map_idx   (map_idx),
        .sda_oe    (sda_oe)
    );

    cfg_reg_bank #(
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (map_idx),
        .wr_data (wr_data),
        .rd_idx  (map_idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
`timescale 1ns/1ps
// Module: cfg_i2c_slave_chk
// Property checker bound into cfg_i2c_slave.
// Assumes: a legal master (SDA moves only while SCL low outside START/STOP,
// low phases longer than the synchronizer delay).
module cfg_i2c_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic                  start_evt,
    input logic                  stop_evt,
    input logic [6:0]            map_idx,
    input logic [NUM_REGS*8-1:0] regs_o
);
    // R11: the open-drain enable only moves while SCL is low.
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i)
        else $error("sda_oe changed while SCL high");

    // R11: register contents only move while SCL is low.
    assert_regs_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> !scl_i)
        else $error("register bank changed while SCL high");

    // R10: STOP leaves the bus released.
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe)
        else $error("SDA still driven after STOP");

    // R10: STOP does not touch the pointer.
    assert_stop_keeps_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> $stable(map_idx))
        else $error("pointer changed on STOP");

    // R10: a START releases SDA for the new address phase.
    assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe)
        else $error("SDA still driven after START");

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .map_idx   (map_idx),
    .regs_o    (regs_o)
);

// File: tb/cfg_i2c_slave_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: bus tasks act as the I2C master; read tasks push the
// expected byte into a queue and a monitor process compares each byte read.
module cfg_i2c_slave_bench;
    localparam int NREG = 8;
    localparam int QT   = 100;      // quarter bit, ten clocks of 10 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = m_sda & ~sda_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_byte;
    event       got_ev;
    logic [7:0] model [1:NREG];
    logic       ack;

    always #5 clk = ~clk;

    cfg_i2c_slave u_cfg_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .regs_o(regs)
    );

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 1; i <= NREG; i++) f[(i-1)*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        m_sda = b;  #(QT);
        m_scl = 1'b1; #(QT);
        s = sda_line; #(QT);
        m_scl = 1'b0; #(QT);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #(QT);
        m_scl = 1'b1; #(QT);
        m_sda = 1'b0; #(QT);
        m_scl = 1'b0; #(QT);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #(QT);
        m_scl = 1'b1; #(QT);
        m_sda = 1'b1; #(QT);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
        xfer_bit(1'b1, s);
        acked = !s;
    endtask

    // Driver: queue the expected byte, clock it out, hand it to the monitor.
    task automatic read_byte(input logic m_ack, input logic [7:0] exp, input string tag);
        logic s;
        logic [7:0] v;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s);
            v[i] = s;
        end
        xfer_bit(!m_ack, s);
        act_byte = v;
        -> got_ev;
    endtask

    // Monitor: compare every byte read against the head of the queue.
    initial begin
        forever begin
            @(got_ev);
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected byte actual=%h expected=none", act_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act_byte !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, act_byte, e);
                end
            end
        end
    end

    initial begin
        #(150000 * 10);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 1; i <= NREG; i++) model[i] = 8'(i * 17);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and released bus
        chk("R1 reset registers", 64'(regs), 64'(model_flat()));
        chk("R1 sda released", 64'(sda_oe), 64'd0);

        // R4 default pointer, R7 ACK ends read with increment off
        bus_start();
        send_byte(8'h23, ack); chk("R2 read address ack", 64'(ack), 64'd1);
        read_byte(1'b1, 8'h11, "R4 default pointer read");
        read_byte(1'b0, 8'hFF, "R7 read ends after one byte");
        bus_stop();

        // R2: strap mismatch and prefix mismatch are ignored
        bus_start();
        send_byte(8'h20, ack); chk("R2 strap mismatch nack", 64'(ack), 64'd0);
        send_byte(8'h83, ack); chk("R2 ignored byte nack", 64'(ack), 64'd0);
        send_byte(8'h5A, ack);
        bus_stop();
        chk("R2 registers untouched", 64'(regs), 64'(model_flat()));
        bus_start();
        send_byte(8'h2B, ack); chk("R2 prefix mismatch nack", 64'(ack), 64'd0);
        bus_stop();

        // R3/R5/R7: pointer load and writes with increment off
        bus_start();
        send_byte(8'h22, ack); chk("R3 write address ack", 64'(ack), 64'd1);
        send_byte(8'h03, ack); chk("R3 pointer byte ack", 64'(ack), 64'd1);
        send_byte(8'hC3, ack); chk("R3 data byte ack", 64'(ack), 64'd1);
        model[3] = 8'hC3;
        chk("R5 write to pointer index", 64'(regs), 64'(model_flat()));
        send_byte(8'h3C, ack);
        model[3] = 8'h3C;
        chk("R7 second write same register", 64'(regs), 64'(model_flat()));
        bus_stop();

        // R6/R8: streaming read with wrap
        bus_start();
        send_byte(8'h22, ack); send_byte(8'h85, ack);
        bus_stop();
        bus_start();
        send_byte(8'h23, ack);
        read_byte(1'b1, 8'h55, "R6 burst read index5");
        read_byte(1'b1, 8'h66, "R6 burst read index6");
        read_byte(1'b1, 8'h77, "R6 burst read index7");
        read_byte(1'b1, 8'h88, "R6 burst read index8");
        read_byte(1'b1, 8'h11, "R8 read wrap to index1");
        read_byte(1'b0, 8'h22, "R8 read after wrap");
        bus_stop();

        // R6/R8: streaming write with wrap
        bus_start();
        send_byte(8'h22, ack); send_byte(8'h87, ack);
        send_byte(8'hA1, ack); send_byte(8'hB2, ack); send_byte(8'hC3, ack);
        bus_stop();
        model[7] = 8'hA1; model[8] = 8'hB2; model[1] = 8'hC3;
        chk("R6 R8 burst write with wrap", 64'(regs), 64'(model_flat()));

        // R9: unimplemented index
        bus_start();
        send_byte(8'h22, ack); send_byte(8'h0A, ack);
        send_byte(8'hEE, ack); chk("R9 unimplemented write ack", 64'(ack), 64'd1);
        bus_stop();
        chk("R9 unimplemented write discarded", 64'(regs), 64'(model_flat()));
        bus_start();
        send_byte(8'h23, ack);
        read_byte(1'b0, 8'h00, "R9 unimplemented read zero");
        bus_stop();

        // R10: repeated START mid-byte
        bus_start();
        send_byte(8'h22, ack); send_byte(8'h02, ack);
        begin
            logic s;
            for (int i = 0; i < 3; i++) xfer_bit(1'b1, s);
        end
        bus_start();
        send_byte(8'h23, ack); chk("R10 address after repeated start", 64'(ack), 64'd1);
        read_byte(1'b0, 8'h22, "R10 read after repeated start");
        bus_stop();
        chk("R10 aborted byte not written", 64'(regs), 64'(model_flat()));
        bus_start();
        send_byte(8'h23, ack);
        read_byte(1'b0, 8'h22, "R10 pointer kept across STOP");
        bus_stop();

        // R2: strap low moves the address
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h22, ack); chk("R2 old address nack", 64'(ack), 64'd0);
        bus_stop();
        bus_start();
        send_byte(8'h20, ack); chk("R2 strap low address ack", 64'(ack), 64'd1);
        send_byte(8'h04, ack); send_byte(8'h4D, ack);
        bus_stop();
        model[4] = 8'h4D;
        chk("R2 write via strap low address", 64'(regs), 64'(model_flat()));

        repeat (5) @(negedge clk);
        chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule